// File: doc/BRIEF.md
# SMRAM Window Remap Decoder

This block sits on the host memory path and decides, for each host address, whether the access belongs to the system-management RAM area of DRAM. If it does, the block produces the DRAM address that the access should use. If it does not, the block passes the host address through unchanged. The decode is purely combinational from the host address, the system-management-mode flag and one 8-bit control register. The control register is written through a simple byte-wide write port and can be read back.

The control register holds two things. A 2-bit remap mode, in bits [7:6], selects one of four windows. Three of them are 32 KB windows at host 0xE0000, which land either on the same DRAM address or on an alias at 0xA0000 or 0xB0000. The fourth is a 64 KB identity window at 0xA0000. The open flag, in bit 4, lets ordinary accesses made outside system-management mode reach the window. While system-management mode is active, the window is always reachable.

A register write takes effect on the decode from the cycle after the clock edge that stores it.

Top module: `smr_remap_dec`

## Requirements
- R1: After reset the control register reads 0x00, which is mode 0 with the open flag clear.
- R2: A write with `cfg_we` high stores the whole `cfg_wdata` byte at the next rising clock edge. `cfg_rdata` returns the stored byte. The register keeps its value while `cfg_we` is low.
- R3: Mode 0 (bits [7:6] = 00) decodes host 0xE0000–0xE7FFF (32 KB) and gives a DRAM address equal to the host address.
- R4: Mode 1 (bits [7:6] = 01) decodes host 0xE0000–0xE7FFF and gives DRAM address 0xA0000 plus the offset into the window.
- R5: Mode 2 (bits [7:6] = 10) decodes host 0xE0000–0xE7FFF and gives DRAM address 0xB0000 plus the offset into the window.
- R6: Mode 3 (bits [7:6] = 11) decodes host 0xA0000–0xAFFFF (64 KB) and gives a DRAM address equal to the host address.
- R7: An address one below the window start, one past the window end, or equal to a window address with any bit set above bit 19 does not hit. In modes 0–2, the range 0xA0000–0xAFFFF does not hit. In mode 3, 0xE0000 does not hit.
- R8: With `smm_active` high, an address inside the window hits whatever the open flag holds. With `smm_active` low, it hits only when bit 4 of the register is set.
- R9: When there is no hit, `smr_hit` is 0 and `phys_addr` equals `host_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Byte to store in the control register |
| cfg_rdata | output | 8 | Current control register contents |
| host_addr | input | 32 | Host memory address being decoded |
| smm_active | input | 1 | High while the processor runs in system-management mode |
| smr_hit | output | 1 | Access is steered to the SMRAM area |
| phys_addr | output | 32 | Translated DRAM address, or `host_addr` on a miss |

## Verification
The hardest case to observe is a hit in mode 0 or mode 3. There the translated address equals the host address, so a decoder that wrongly misses produces the same `phys_addr`. Only the hit flag tells the two apart. The stimulus therefore sweeps every mode against both open-flag settings and both values of the mode flag. At each point it probes the first and last window addresses, the addresses just outside them, and an address that differs only above bit 19. The expected hit flag and address are compared at every point, so a pass-through cannot hide a missed hit.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [1:0] {
    SMR_E_SAME = 2'd0,
    SMR_E_TO_A = 2'd1,
    SMR_E_TO_B = 2'd2,
    SMR_A_SAME = 2'd3
  } smr_mode_e;

  localparam logic [31:0] SMR_E_BASE   = 32'h000E_0000;
  localparam logic [31:0] SMR_A_BASE   = 32'h000A_0000;
  localparam logic [31:0] SMR_B_BASE   = 32'h000B_0000;
  localparam logic [31:0] SMR_SMALL_SZ = 32'h0000_8000;
  localparam logic [31:0] SMR_LARGE_SZ = 32'h0001_0000;

  // Host-side start of the window for a mode
  function automatic logic [31:0] smr_win_base(smr_mode_e m);
    return (m == SMR_A_SAME) ? SMR_A_BASE : SMR_E_BASE;
  endfunction

  // Window length in bytes for a mode
  function automatic logic [31:0] smr_win_size(smr_mode_e m);
    return (m == SMR_A_SAME) ? SMR_LARGE_SZ : SMR_SMALL_SZ;
  endfunction

  // DRAM-side start of the window for a mode
  function automatic logic [31:0] smr_dram_base(smr_mode_e m);
    logic [31:0] b;
    case (m)
      SMR_E_SAME: b = SMR_E_BASE;
      SMR_E_TO_A: b = SMR_A_BASE;
      SMR_E_TO_B: b = SMR_B_BASE;
      default:    b = SMR_A_BASE;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/smr_cfg_reg.sv
module smr_cfg_reg
  import smr_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int MODE_LSB = 6,
  parameter int OPEN_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output smr_mode_e        mode,
  output logic             open_en
);

  logic [CFG_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  assign rdata   = ctl_q;
  assign mode    = smr_mode_e'(ctl_q[MODE_LSB +: 2]);
  assign open_en = ctl_q[OPEN_BIT];

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == $past(wdata)));

endmodule

// File: rtl/smr_window_match.sv
module smr_window_match
  import smr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] host_addr,
  input  smr_mode_e         mode,
  output logic              in_win,
  output logic [ADDR_W-1:0] offset
);

  logic [31:0]       base32;
  logic [31:0]       size32;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] size_w;
  logic [ADDR_W-1:0] diff;

  assign base32 = smr_win_base(mode);
  assign size32 = smr_win_size(mode);
  assign base_w = base32[ADDR_W-1:0];
  assign size_w = size32[ADDR_W-1:0];
  assign diff   = host_addr - base_w;

  assign in_win = (host_addr >= base_w) && (diff < size_w);
  assign offset = diff;

endmodule

// File: rtl/smr_addr_xlate.sv
module smr_addr_xlate
  import smr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [ADDR_W-1:0] offset,
  input  smr_mode_e         mode,
  input  logic              hit,
  output logic [ADDR_W-1:0] phys_addr
);

  logic [31:0]       dbase32;
  logic [ADDR_W-1:0] dbase_w;
  logic [ADDR_W-1:0] remapped;

  assign dbase32  = smr_dram_base(mode);
  assign dbase_w  = dbase32[ADDR_W-1:0];
  assign remapped = dbase_w + offset;

  assign phys_addr = hit ? remapped : host_addr;

  // R3 R4 R5: the offset into a 32 KB page survives translation
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (phys_addr[14:0] == host_addr[14:0]));

  // R4
  alias_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == SMR_E_TO_A) |-> (phys_addr[ADDR_W-1:15] == (32'h000A_0000 >> 15)));

  // R5
  alias_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == SMR_E_TO_B) |-> (phys_addr[ADDR_W-1:15] == (32'h000B_0000 >> 15)));

endmodule

// File: rtl/smr_remap_dec.sv
module smr_remap_dec
  import smr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CFG_W    = 8,
  parameter int MODE_LSB = 6,
  parameter int OPEN_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              smm_active,
  output logic              smr_hit,
  output logic [ADDR_W-1:0] phys_addr
);

  smr_mode_e         mode;
  logic              open_en;
  logic              win_match;
  logic [ADDR_W-1:0] win_offset;
  logic              access_ok;

  smr_cfg_reg #(
    .CFG_W   (CFG_W),
    .MODE_LSB(MODE_LSB),
    .OPEN_BIT(OPEN_BIT)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .mode   (mode),
    .open_en(open_en)
  );

  smr_window_match #(.ADDR_W(ADDR_W)) u_match (
    .host_addr(host_addr),
    .mode     (mode),
    .in_win   (win_match),
    .offset   (win_offset)
  );

  assign access_ok = smm_active | open_en;
  assign smr_hit   = win_match & access_ok;

  smr_addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_addr(host_addr),
    .offset   (win_offset),
    .mode     (mode),
    .hit      (smr_hit),
    .phys_addr(phys_addr)
  );

  // R9
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smr_hit |-> (phys_addr == host_addr));

  // R8
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && !smm_active) |-> cfg_rdata[OPEN_BIT]);

  // R7
  hit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smr_hit |-> ((host_addr >= 32'h000A_0000 && host_addr < 32'h000B_0000) ||
                 (host_addr >= 32'h000E_0000 && host_addr < 32'h000E_8000)));

  // R3 R6
  identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smr_hit && (mode == SMR_A_SAME || mode == SMR_E_SAME)) |-> (phys_addr == host_addr));

endmodule

// File: tb/smr_remap_dec_tb.sv
module smr_remap_dec_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] host_addr = '0;
  logic        smm_active = 1'b0;
  logic        smr_hit;
  logic [31:0] phys_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  smr_remap_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .host_addr(host_addr), .smm_active(smm_active),
    .smr_hit(smr_hit), .phys_addr(phys_addr)
  );

  typedef struct {
    logic [31:0] host;
    logic        hit;
    logic [31:0] phys;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;

  // Reference view: mode 3 decodes the 64 KB page 0xA; other modes decode
  // 32 KB page 0x1C and replace the page number.
  function automatic void ref_model(input logic [1:0] m, input logic opn,
                                    input logic smm, input logic [31:0] a,
                                    output logic h, output logic [31:0] p);
    logic in;
    logic [16:0] pg;
    if (m == 2'd3) begin
      in = (a[31:16] == 16'h000A);
      p  = a;
    end else begin
      in = (a[31:15] == 17'h0001C);
      pg = (m == 2'd1) ? 17'h00014 : (m == 2'd2) ? 17'h00016 : 17'h0001C;
      p  = {pg, a[14:0]};
    end
    h = in && (smm || opn);
    if (!h) p = a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = 8'h5A;
  endtask

  task automatic drive(input logic [1:0] m, input logic opn, input logic smm,
                       input logic [31:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    host_addr = a;
    smm_active = smm;
    ref_model(m, opn, smm, a, e.hit, e.phys);
    e.host = a;
    e.tag = tag;
    sb_q.push_back(e);
    #2;
    ->sample_ev;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check({e.tag, " hit"}, {31'd0, smr_hit}, {31'd0, e.hit});
        check({e.tag, " phys"}, phys_addr, e.phys);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic string pick_tag(input logic [1:0] m, input logic opn,
                                     input logic smm, input logic [31:0] a);
    logic h;
    logic [31:0] p;
    ref_model(m, opn, smm, a, h, p);
    if (!h) return (a[31:20] != 0) ? "R7 high bits" : "R9/R7 miss";
    if (!smm) return "R8 open";
    case (m)
      2'd0: return "R3 mode0";
      2'd1: return "R4 mode1";
      2'd2: return "R5 mode2";
      default: return "R6 mode3";
    endcase
  endfunction

  logic [31:0] probes [12] = '{
    32'h000D_FFFF, 32'h000E_0000, 32'h000E_1234, 32'h000E_7FFF,
    32'h000E_8000, 32'h0009_FFFF, 32'h000A_0000, 32'h000A_8ABC,
    32'h000A_FFFF, 32'h000B_0000, 32'h100E_0000, 32'h001A_0000
  };

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset value
    check("R1 reset reg", {24'd0, cfg_rdata}, 32'h0);
    rst_n = 1'b1;
    drive(2'd0, 1'b0, 1'b0, 32'h000E_0000, "R1 closed after reset");
    drive(2'd0, 1'b0, 1'b1, 32'h000E_0000, "R1 mode0 after reset");

    // R2: full-byte store and hold
    cfg_write(8'hFF);
    check("R2 readback", {24'd0, cfg_rdata}, 32'hFF);
    repeat (3) @(negedge clk);
    check("R2 hold", {24'd0, cfg_rdata}, 32'hFF);
    cfg_write(8'h2D);
    check("R2 readback2", {24'd0, cfg_rdata}, 32'h2D);

    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        logic [7:0] v;
        v = {m[1:0], 1'b0, o[0], 4'b0000};
        cfg_write(v);
        check("R2 mode readback", {24'd0, cfg_rdata}, {24'd0, v});
        for (int s = 0; s < 2; s++) begin
          for (int k = 0; k < 12; k++) begin
            drive(m[1:0], o[0], s[0], probes[k],
                  pick_tag(m[1:0], o[0], s[0], probes[k]));
          end
        end
      end
    end

    // R8: open flag change takes effect on the decode right after the write
    cfg_write(8'h40);
    drive(2'd1, 1'b0, 1'b0, 32'h000E_4000, "R8 closed mode1");
    cfg_write(8'h50);
    drive(2'd1, 1'b1, 1'b0, 32'h000E_4000, "R8 opened mode1");

    @(negedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule